// File: doc/BRIEF.md
# Permutation-Preserving Tour Crossover Unit

This block builds one child tour from two parent tours for a genetic search over city orderings. Each tour is a list of `N_CITIES` city indices in which every city occurs exactly once. After a start request the unit captures both parents and draws a cut position from its own free-running linear feedback shift register. It copies the leading part of the first parent up to the cut. It then walks the remaining positions of the second parent and keeps only cities not yet used. Finally it fills the gaps with leftover cities picked at random. The child is therefore always a valid permutation.

A bitmap of still-unused cities, one bit per city, tracks which cities remain. A separate per-slot filled flag marks the gaps, so no city code is reserved to mean "empty". The unit handles one slot per clock in every phase, which gives a fixed operation length. A one-cycle `done` pulse marks the moment the child tour is complete on its output.

Top module: `tour_xover`

## Requirements
- R1: While reset is asserted and afterwards until the first start, `busy` and `done` are low and every child slot reads 0.
- R2: A high `start` sampled at a rising edge while `busy` is low is accepted. At that edge the unit captures `parent_a` and `parent_b` and sets the cut position to the random register's value at that edge modulo `N_CITIES`.
- R3: Child slots 0 through the cut position, inclusive, hold the first parent's city at the same slot.
- R4: For each slot after the cut, in ascending order, the second parent's city at that slot is placed in the child if no earlier slot already holds it. Otherwise the slot stays empty for now.
- R5: Empty slots are then filled in ascending slot order, one slot position per clock. Slot p is handled at the edge N_CITIES+1+p edges after the accepting edge. It takes the first unused city found from (random value at that edge modulo `N_CITIES`) upward, wrapping past N_CITIES-1 to 0.
- R6: When `done` is high, the child holds every city index from 0 to N_CITIES-1 exactly once. City index p sits in bits [p*CW +: CW] of a tour bus, CW = ceil(log2 N_CITIES).
- R7: `busy` is high after the accepting edge through the 2*N_CITIES-th edge after it. `done` is high for exactly one cycle, after edge 2*N_CITIES, with `busy` low.
- R8: A `start` raised while `busy` is high is ignored. Changes on the parent inputs after the accepting edge do not affect the child.
- R9: The random register is 16 bits wide and is reset to 0xACE1. At every rising edge out of reset it shifts left by one and takes as its new bit 0 the XOR of bits 15, 13, 12 and 10.
- R10: While the unit is idle and no start is accepted, the child output holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a crossover; accepted only when idle |
| parent_a | input | N_CITIES*CW | First parent tour; supplies the head |
| parent_b | input | N_CITIES*CW | Second parent tour; supplies the tail |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: child complete |
| child | output | N_CITIES*CW | Child tour |

## Verification
Every result has a fixed due cycle counted from the accepting edge k. The cut uses the random value present at edge k. Head slot p is written at edge k+1+p and tail slots follow directly. Fill slot p is written at edge k+N_CITIES+1+p, and `done` and the finished child appear after edge k+2*N_CITIES. The bench keeps its own copy of the random sequence, indexed by edge number, and works out the expected child from those values. It compares `busy` and `done` at the falling edge of every clock against the window derived from k, and checks each child slot at the falling edge that follows edge k+2*N_CITIES.

// File: rtl/tour_xover_pkg.sv
package tour_xover_pkg;

    // Phase of the crossover sequence; idle must be the all-zero code.
    typedef enum logic [1:0] {
        XO_IDLE = 2'd0,
        XO_HEAD = 2'd1,
        XO_TAIL = 2'd2,
        XO_FILL = 2'd3
    } xo_phase_e;

endpackage

// File: rtl/tour_xover_lfsr.sv
module tour_xover_lfsr #(
    parameter int              W    = 16,
    parameter logic [W-1:0]    TAPS = 16'hB400,
    parameter logic [W-1:0]    SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] value
);

    logic [W-1:0] sr_d;
    logic [W-1:0] sr_q;

    always_comb begin
        sr_d = {sr_q[W-2:0], ^(sr_q & TAPS)};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= SEED;
        end else begin
            sr_q <= sr_d;
        end
    end

    assign value = sr_q;

endmodule

// File: rtl/tour_xover_pick.sv
module tour_xover_pick #(
    parameter int N_CITIES = 8,
    localparam int CW      = $clog2(N_CITIES)
) (
    input  logic [N_CITIES-1:0] avail,
    input  logic [CW-1:0]       origin,
    output logic [CW-1:0]       pick,
    output logic                found
);

    int           sum;
    logic [CW-1:0] idx;

    // Scan downward so the closest set bit at or after origin wins last.
    always_comb begin
        found = 1'b0;
        pick  = '0;
        sum   = 0;
        idx   = '0;
        for (int j = N_CITIES - 1; j >= 0; j--) begin
            sum = int'(origin) + j;
            if (sum >= N_CITIES) begin
                sum = sum - N_CITIES;
            end
            idx = CW'(sum);
            if (avail[idx]) begin
                found = 1'b1;
                pick  = idx;
            end
        end
    end

endmodule

// File: rtl/tour_xover.sv
module tour_xover
    import tour_xover_pkg::*;
#(
    parameter int                N_CITIES  = 8,
    parameter int                LFSR_W    = 16,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
    localparam int               CW        = $clog2(N_CITIES),
    localparam int               TOUR_W    = N_CITIES * CW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [TOUR_W-1:0] parent_a,
    input  logic [TOUR_W-1:0] parent_b,
    output logic              busy,
    output logic              done,
    output logic [TOUR_W-1:0] child
);

    localparam logic [CW-1:0] LAST_SLOT = CW'(N_CITIES - 1);
    localparam logic [CW-1:0] STEP      = CW'(1);

    typedef struct packed {
        xo_phase_e                    phase;
        logic [CW-1:0]                slot;
        logic [CW-1:0]                cut;
        logic [N_CITIES-1:0]          unused;
        logic [N_CITIES-1:0]          filled;
        logic [N_CITIES-1:0][CW-1:0]  tour_a;
        logic [N_CITIES-1:0][CW-1:0]  tour_b;
        logic [N_CITIES-1:0][CW-1:0]  kid;
        logic                         fin;
    } xo_regs_t;

    xo_regs_t r_d;
    xo_regs_t r_q;

    logic [LFSR_W-1:0] rnd;
    logic [CW-1:0]     rnd_idx;
    logic [CW-1:0]     fill_city;
    logic              fill_ok;
    logic [CW-1:0]     head_city;
    logic [CW-1:0]     tail_city;

    tour_xover_lfsr #(
        .W    (LFSR_W),
        .TAPS (LFSR_TAPS),
        .SEED (LFSR_SEED)
    ) rng_i (
        .clk   (clk),
        .rst_n (rst_n),
        .value (rnd)
    );

    assign rnd_idx = CW'(rnd % LFSR_W'(N_CITIES));

    tour_xover_pick #(
        .N_CITIES (N_CITIES)
    ) pick_i (
        .avail  (r_q.unused),
        .origin (rnd_idx),
        .pick   (fill_city),
        .found  (fill_ok)
    );

    assign head_city = r_q.tour_a[r_q.slot];
    assign tail_city = r_q.tour_b[r_q.slot];

    always_comb begin
        r_d     = r_q;
        r_d.fin = 1'b0;
        unique case (r_q.phase)
            XO_IDLE: begin
                if (start) begin
                    r_d.tour_a = parent_a;
                    r_d.tour_b = parent_b;
                    r_d.cut    = rnd_idx;
                    r_d.unused = '1;
                    r_d.filled = '0;
                    r_d.slot   = '0;
                    r_d.phase  = XO_HEAD;
                end
            end
            XO_HEAD: begin
                r_d.kid[r_q.slot]    = head_city;
                r_d.filled[r_q.slot] = 1'b1;
                r_d.unused[head_city] = 1'b0;
                if (r_q.slot == r_q.cut) begin
                    if (r_q.cut == LAST_SLOT) begin
                        r_d.slot  = '0;
                        r_d.phase = XO_FILL;
                    end else begin
                        r_d.slot  = r_q.slot + STEP;
                        r_d.phase = XO_TAIL;
                    end
                end else begin
                    r_d.slot = r_q.slot + STEP;
                end
            end
            XO_TAIL: begin
                if (r_q.unused[tail_city]) begin
                    r_d.kid[r_q.slot]     = tail_city;
                    r_d.filled[r_q.slot]  = 1'b1;
                    r_d.unused[tail_city] = 1'b0;
                end
                if (r_q.slot == LAST_SLOT) begin
                    r_d.slot  = '0;
                    r_d.phase = XO_FILL;
                end else begin
                    r_d.slot = r_q.slot + STEP;
                end
            end
            XO_FILL: begin
                if (!r_q.filled[r_q.slot] && fill_ok) begin
                    r_d.kid[r_q.slot]     = fill_city;
                    r_d.filled[r_q.slot]  = 1'b1;
                    r_d.unused[fill_city] = 1'b0;
                end
                if (r_q.slot == LAST_SLOT) begin
                    r_d.slot  = '0;
                    r_d.phase = XO_IDLE;
                    r_d.fin   = 1'b1;
                end else begin
                    r_d.slot = r_q.slot + STEP;
                end
            end
            default: begin
                r_d.phase = XO_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy  = (r_q.phase != XO_IDLE);
    assign done  = r_q.fin;
    assign child = r_q.kid;

endmodule

// File: rtl/tour_xover_chk.sv
module tour_xover_chk #(
    parameter int N_CITIES = 8,
    localparam int CW      = $clog2(N_CITIES),
    localparam int TOUR_W  = N_CITIES * CW,
    localparam int CNT_W   = $clog2(2 * N_CITIES + 2) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [TOUR_W-1:0] child
);

    localparam logic [CNT_W-1:0] DONE_AT = CNT_W'(2 * N_CITIES + 1);

    logic [N_CITIES-1:0] seen;
    logic [CNT_W-1:0]    run_cnt;

    always_comb begin
        seen = '0;
        for (int i = 0; i < N_CITIES; i++) begin
            seen[child[i*CW +: CW]] = 1'b1;
        end
    end

    // Edges elapsed since the accepting edge, counted inclusively.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (start && !busy) begin
            run_cnt <= CNT_W'(1);
        end else if (busy) begin
            run_cnt <= run_cnt + CNT_W'(1);
        end
    end

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_child_perm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (&seen));

    assert_done_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_done_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt == DONE_AT));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(child));

endmodule

bind tour_xover tour_xover_chk #(.N_CITIES(N_CITIES)) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .child (child)
);

// File: tb/tour_xover_tb_top.sv
module tour_xover_tb_top;

    localparam int N  = 8;
    localparam int CW = 3;
    localparam int TW = N * CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [TW-1:0] pa_in = '0;
    logic [TW-1:0] pb_in = '0;
    wire           busy;
    wire           done;
    wire  [TW-1:0] child;

    always #10 clk = ~clk;

    tour_xover #(.N_CITIES(N)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .parent_a (pa_in),
        .parent_b (pb_in),
        .busy     (busy),
        .done     (done),
        .child    (child)
    );

    int checks = 0;
    int bad    = 0;
    bit mon_en = 1'b0;
    bit op_on  = 1'b0;
    int op_k   = 0;
    bit ended  = 1'b0;
    logic [TW-1:0] last_kid = '0;

    // R9: behavioural model of the random register, value logged per edge.
    logic [15:0] m_rnd = 16'hACE1;
    logic [15:0] hist[$];

    always @(posedge clk) begin
        hist.push_back(m_rnd);
        if (!rst_n) m_rnd <= 16'hACE1;
        else        m_rnd <= {m_rnd[14:0], m_rnd[15] ^ m_rnd[13] ^ m_rnd[12] ^ m_rnd[10]};
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // R7: busy/done window compared at every falling edge.
    int  sz;
    bit  exp_busy;
    bit  exp_done;
    always @(negedge clk) begin
        if (mon_en) begin
            sz       = hist.size();
            exp_busy = op_on && (sz >= op_k + 1) && (sz <= op_k + 2 * N);
            exp_done = op_on && (sz == op_k + 2 * N + 1);
            chk(busy == exp_busy, "R7", "busy", longint'(busy), longint'(exp_busy));
            chk(done == exp_done, "R7", "done", longint'(done), longint'(exp_done));
        end
    end

    function automatic logic [TW-1:0] make_tour(input int mode);
        int a[N];
        int j;
        int t;
        logic [TW-1:0] v;
        for (int i = 0; i < N; i++) a[i] = i;
        if (mode == 1) begin
            for (int i = 0; i < N; i++) a[i] = N - 1 - i;
        end else if (mode == 2) begin
            for (int i = 0; i < N; i++) a[i] = (i + 3) % N;
        end else if (mode >= 3) begin
            for (int i = N - 1; i > 0; i--) begin
                j = int'($urandom % (i + 1));
                t = a[i]; a[i] = a[j]; a[j] = t;
            end
        end
        v = '0;
        for (int i = 0; i < N; i++) v[i*CW +: CW] = CW'(a[i]);
        return v;
    endfunction

    task automatic run_op(input logic [TW-1:0] a, input logic [TW-1:0] b, input bit disturb);
        int cut;
        int r;
        int c;
        int k;
        int pool[N];
        int ch[N];
        int cat[N];
        logic [N-1:0] seen;
        logic [CW-1:0] got;
        @(negedge clk);
        pa_in = a; pb_in = b; start = 1'b1;
        k = hist.size();
        op_k = k; op_on = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R8: late parent changes and a start while busy must not matter.
        pa_in = b; pb_in = a;
        if (disturb) begin
            repeat (3) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (hist.size() < k + 2 * N + 1) @(negedge clk);
        // Expected child from the requirements.
        cut = int'(hist[k]) % N;
        for (int i = 0; i < N; i++) begin pool[i] = 1; ch[i] = -1; cat[i] = 0; end
        for (int p = 0; p <= cut; p++) begin
            ch[p] = int'(a[p*CW +: CW]); pool[ch[p]] = 0; cat[p] = 3;
        end
        for (int p = cut + 1; p < N; p++) begin
            c = int'(b[p*CW +: CW]);
            if (pool[c] == 1) begin ch[p] = c; pool[c] = 0; cat[p] = 4; end
        end
        for (int p = 0; p < N; p++) begin
            if (ch[p] < 0) begin
                r = int'(hist[k + N + 1 + p]) % N;
                for (int j = 0; j < N; j++) begin
                    c = (r + j) % N;
                    if (ch[p] < 0 && pool[c] == 1) begin ch[p] = c; pool[c] = 0; cat[p] = 5; end
                end
            end
        end
        seen = '0;
        for (int p = 0; p < N; p++) begin
            got = child[p*CW +: CW];
            seen[got] = 1'b1;
            if (cat[p] == 3)      chk(int'(got) == ch[p], "R3", "head slot (cut per R2)", longint'(got), longint'(ch[p]));
            else if (cat[p] == 4) chk(int'(got) == ch[p], "R4", "tail slot", longint'(got), longint'(ch[p]));
            else                  chk(int'(got) == ch[p], "R5", "fill slot (R9 sequence)", longint'(got), longint'(ch[p]));
        end
        chk(&seen, "R6", "permutation", longint'(seen), longint'({N{1'b1}}));
        if (disturb) chk(1'b1 && (&seen), "R8", "start while busy ignored", longint'(busy), 0);
        for (int p = 0; p < N; p++) last_kid[p*CW +: CW] = CW'(ch[p]);
        @(negedge clk);
        op_on = 1'b0;
    endtask

    initial begin : watchdog
        #(20 * 150000);
        if (!ended) begin
            checks++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1", "busy in reset", longint'(busy), 0);
        chk(done == 1'b0, "R1", "done in reset", longint'(done), 0);
        chk(child == '0, "R1", "child in reset", longint'(child), 0);
        rst_n = 1'b1;
        mon_en = 1'b1;
        repeat (2) @(negedge clk);
        chk(child == '0, "R1", "child after reset", longint'(child), 0);

        run_op(make_tour(0), make_tour(0), 1'b0);
        run_op(make_tour(0), make_tour(1), 1'b0);
        run_op(make_tour(1), make_tour(0), 1'b1);
        run_op(make_tour(2), make_tour(1), 1'b0);
        // R10: child holds while idle.
        repeat (5) @(negedge clk);
        chk(child == last_kid, "R10", "hold while idle", longint'(child), longint'(last_kid));
        for (int n = 0; n < 40; n++) begin
            run_op(make_tour(3), make_tour(3), (n % 4) == 1);
            repeat (n % 3) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        chk(child == last_kid, "R10", "hold after last run", longint'(child), longint'(last_kid));
        ended = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule